// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request of a small controller into one internal reset and one shared reset pin. Requests come from the active-low reset pin, which the board may pull low, and from four internal causes: power-on, watchdog expiry, an illegal opcode and an illegal address. When an internal cause fires, the block pulls the shared pin low through an open-drain enable for a fixed number of clock cycles so that devices on the board reset too. It then keeps the internal reset asserted for a second fixed window after the pin is let go.

Power-on first runs a long stabilization count with the pin held low, then the normal drive-and-hold sequence. A low level on the pin, after a two-flop synchronizer, holds the internal reset for as long as it lasts. The pin's cause bit is recorded only when the low level lasts a minimum number of clock edges. One counter serves both the sequence and that low-time measurement. An internal reset clears it; a pin reset does not restart the sequence. The cause bits are sticky until the processor reads them outside reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, `pin_pull_lo` and `rst_int` are 1 and `rst_cause` is 5'b10000. The cause bit layout is [4] power-on, [3] watchdog, [2] illegal opcode, [1] illegal address, [0] pin. After the first clock edge that follows the release of `por_n`, the pull stays on through edge POR_CYC+DRIVE_CYC and is off after it. `rst_int` falls after edge POR_CYC+DRIVE_CYC+HOLD_CYC.
- R2: An internal request sampled high at edge E outside stabilization turns `pin_pull_lo` on after E. It stays on through edge E+DRIVE_CYC-1 and is off after edge E+DRIVE_CYC.
- R3: After the pull is released, `rst_int` stays 1 through edge E+DRIVE_CYC+HOLD_CYC-1 and is 0 after edge E+DRIVE_CYC+HOLD_CYC, provided the pin is not held low from outside.
- R4: Each internal request sets its own cause bit at the edge that samples it.
- R5: A request that arrives during drive or hold restarts the sequence at drive. Its cause bit is added to the bits already recorded.
- R6: A request during power-on stabilization sets its cause bit but neither shortens nor restarts the power-on sequence.
- R7: A pin low level sampled at PIN_MIN consecutive clock edges while the block is idle sets cause bit [0]. PIN_MIN-1 edges do not set it.
- R8: `rst_int` rises after the second clock edge that samples the pin low, and stays 0 after the first. A pin reset never turns on `pin_pull_lo`.
- R9: `stat_rd` high at an edge while `rst_int` is 0 clears `rst_cause`. While `rst_int` is 1, `stat_rd` is ignored.
- R10: When a read clear and a new cause fall on the same edge, only the new cause bit remains.
- R11: An internal reset clears the pin low-time count, so low time seen before the reset does not add to low time seen after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous |
| pin_in | input | 1 | Level read back from the shared reset pin |
| wdog_req | input | 1 | Watchdog expiry request pulse |
| bad_op_req | input | 1 | Illegal opcode request pulse |
| bad_addr_req | input | 1 | Illegal address request pulse |
| stat_rd | input | 1 | Processor read strobe of the cause register |
| pin_pull_lo | output | 1 | Open-drain pull-down enable for the shared pin |
| rst_int | output | 1 | Internal reset to the rest of the chip |
| rst_cause | output | 5 | Sticky reset cause bits |

## Verification
Two functions can meet at one edge: the read clear of the cause register and the setting of a new cause bit. The bench provokes this by raising `stat_rd` and an illegal address request together while idle, with an older watchdog bit still recorded. It expects only the new bit to survive. A second collision puts an internal request on top of a pin low-time count that is already running. The bench judges it by checking that the pin cause bit stays clear, even though the total low time is well above the threshold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STAB  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    localparam int CAUSE_W = 5;
    localparam int C_PIN   = 0;
    localparam int C_ADDR  = 1;
    localparam int C_OP    = 2;
    localparam int C_WDOG  = 3;
    localparam int C_POR   = 4;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_CYC   = 4096,
    parameter int DRIVE_CYC = 32,
    parameter int HOLD_CYC  = 32,
    parameter int PIN_MIN   = 67
) (
    input  logic clk,
    input  logic por_n,
    input  logic int_req,
    input  logic pin_lo,
    output logic pull_lo,
    output logic busy,
    output logic pin_qual
);
    localparam int MAXC = (POR_CYC > PIN_MIN) ? POR_CYC : PIN_MIN;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        pin_qual = 1'b0;
        unique case (cur_q.st)
            ST_STAB: begin
                if (cur_q.cnt == CW'(POR_CYC - 1)) begin
                    nxt_d.st  = ST_DRIVE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_DRIVE: begin
                if (int_req) begin
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == CW'(DRIVE_CYC - 1)) begin
                    nxt_d.st  = ST_HOLD;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (int_req) begin
                    nxt_d.st  = ST_DRIVE;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == CW'(HOLD_CYC - 1)) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                if (int_req) begin
                    nxt_d.st  = ST_DRIVE;
                    nxt_d.cnt = '0;
                end else if (pin_lo) begin
                    if (cur_q.cnt < CW'(PIN_MIN)) begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                        pin_qual  = (cur_q.cnt == CW'(PIN_MIN - 1));
                    end
                end else begin
                    nxt_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '{st: ST_STAB, cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign pull_lo = (cur_q.st == ST_STAB) || (cur_q.st == ST_DRIVE);
    assign busy    = (cur_q.st != ST_IDLE);

    AST_REQ_PULLS: assert property (@(posedge clk) disable iff (!por_n)
        (int_req && cur_q.st != ST_STAB) |=> (pull_lo && cur_q.cnt == '0)) else $error("AST_REQ_PULLS"); // R2
    AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(pull_lo) && !$past(int_req)) |-> (busy && cur_q.cnt == '0)) else $error("AST_HOLD_FOLLOWS"); // R3
    AST_STAB_FULL: assert property (@(posedge clk) disable iff (!por_n)
        ($past(cur_q.st) == ST_STAB && cur_q.st != ST_STAB) |-> ($past(cur_q.cnt) == CW'(POR_CYC - 1))) else $error("AST_STAB_FULL"); // R6
    AST_QUAL_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        pin_qual |-> (pin_lo && !busy && !int_req)) else $error("AST_QUAL_IDLE"); // R7
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr,
    output logic [CAUSE_W-1:0] status
);
    logic [CAUSE_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (clr ? '0 : stat_q) | set_vec;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stat_q <= CAUSE_W'(1) << C_POR;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;

    AST_CAUSE_STICKS: assert property (@(posedge clk) disable iff (!por_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))) else $error("AST_CAUSE_STICKS"); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (clr && set_vec == '0) |=> (status == '0)) else $error("AST_READ_CLEARS"); // R9
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int POR_CYC   = 4096,
    parameter int DRIVE_CYC = 32,
    parameter int HOLD_CYC  = 32,
    parameter int SYNC_N    = 2,
    parameter int PIN_MIN   = DRIVE_CYC + HOLD_CYC + 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               pin_in,
    input  logic               wdog_req,
    input  logic               bad_op_req,
    input  logic               bad_addr_req,
    input  logic               stat_rd,
    output logic               pin_pull_lo,
    output logic               rst_int,
    output logic [CAUSE_W-1:0] rst_cause
);
    logic pin_s, pin_lo, busy, pin_qual, int_req, rd_clr;
    logic [CAUSE_W-1:0] set_vec;

    rstseq_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .por_n(por_n), .d_in(pin_in), .q_out(pin_s)
    );

    assign pin_lo  = ~pin_s;
    assign int_req = wdog_req | bad_op_req | bad_addr_req;

    rstseq_fsm #(
        .POR_CYC(POR_CYC), .DRIVE_CYC(DRIVE_CYC),
        .HOLD_CYC(HOLD_CYC), .PIN_MIN(PIN_MIN)
    ) u_fsm (
        .clk(clk), .por_n(por_n), .int_req(int_req), .pin_lo(pin_lo),
        .pull_lo(pin_pull_lo), .busy(busy), .pin_qual(pin_qual)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[C_PIN]  = pin_qual;
        set_vec[C_ADDR] = bad_addr_req;
        set_vec[C_OP]   = bad_op_req;
        set_vec[C_WDOG] = wdog_req;
    end

    assign rst_int = busy | pin_lo;
    assign rd_clr  = stat_rd & ~rst_int;

    rstseq_cause u_cause (
        .clk(clk), .por_n(por_n), .set_vec(set_vec), .clr(rd_clr), .status(rst_cause)
    );

    AST_PULL_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull_lo |-> rst_int) else $error("AST_PULL_IN_RST"); // R2
    AST_READ_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (stat_rd && rst_int && !int_req && !pin_qual) |=> $stable(rst_cause)) else $error("AST_READ_IGNORED"); // R9
endmodule

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
    localparam int POR_CYC = 4096;
    localparam int DRV     = 32;
    localparam int HLD     = 32;
    localparam int PMIN    = DRV + HLD + 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_lo = 1'b0;
    logic wdog_req = 1'b0, bad_op_req = 1'b0, bad_addr_req = 1'b0, stat_rd = 1'b0;
    logic pin_pull_lo, rst_int;
    logic [4:0] rst_cause;
    wire  pin_in = ~(ext_lo | pin_pull_lo);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rst_sequencer #(.POR_CYC(POR_CYC), .DRIVE_CYC(DRV), .HOLD_CYC(HLD)) u0 (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .wdog_req(wdog_req),
        .bad_op_req(bad_op_req), .bad_addr_req(bad_addr_req), .stat_rd(stat_rd),
        .pin_pull_lo(pin_pull_lo), .rst_int(rst_int), .rst_cause(rst_cause)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cause();
        stat_rd = 1'b1; nwait(1); stat_rd = 1'b0;
        chk("R9 read clears", rst_cause, 5'b00000);
    endtask

    // R1 power-on, optional R6 request during stabilization
    task automatic t_por(input bit with_req);
        @(negedge clk); por_n = 1'b0; nwait(2);
        chk("R1 reset pull", pin_pull_lo, 1); chk("R1 reset rst", rst_int, 1);
        chk("R1 reset cause", rst_cause, 5'b10000);
        por_n = 1'b1;
        if (with_req) begin
            nwait(100); bad_addr_req = 1'b1; nwait(1); bad_addr_req = 1'b0;
            chk("R6 cause in stab", rst_cause, 5'b10010);
            nwait(POR_CYC + DRV - 1 - 101);
        end else nwait(POR_CYC + DRV - 1);
        chk("R1 pull held", pin_pull_lo, 1);
        nwait(1);
        chk(with_req ? "R6 pull release" : "R1 pull release", pin_pull_lo, 0);
        chk("R1 rst after pull", rst_int, 1);
        nwait(HLD - 1); chk("R1 rst held", rst_int, 1);
        nwait(1); chk(with_req ? "R6 rst release" : "R1 rst release", rst_int, 0);
        chk("R1 cause", rst_cause, with_req ? 5'b10010 : 5'b10000);
        clear_cause();
    endtask

    // R2 R3 R4 single internal request
    task automatic t_int(input int which, input logic [4:0] exp);
        case (which)
            0: wdog_req = 1'b1;
            1: bad_op_req = 1'b1;
            default: bad_addr_req = 1'b1;
        endcase
        nwait(1); wdog_req = 1'b0; bad_op_req = 1'b0; bad_addr_req = 1'b0;
        chk("R2 pull on", pin_pull_lo, 1); chk("R2 rst on", rst_int, 1);
        nwait(DRV - 1); chk("R2 pull held", pin_pull_lo, 1);
        nwait(1); chk("R2 pull off", pin_pull_lo, 0); chk("R3 rst held", rst_int, 1);
        nwait(HLD - 1); chk("R3 rst held end", rst_int, 1);
        nwait(1); chk("R3 rst off", rst_int, 0);
        chk("R4 own bit", rst_cause, exp);
        clear_cause();
    endtask

    // R5 restart during drive
    task automatic t_restart();
        wdog_req = 1'b1; nwait(1); wdog_req = 1'b0;
        nwait(20);
        bad_op_req = 1'b1; nwait(1); bad_op_req = 1'b0;
        nwait(DRV - 1); chk("R5 pull extended", pin_pull_lo, 1);
        nwait(1); chk("R5 pull off", pin_pull_lo, 0);
        nwait(HLD); chk("R5 rst off", rst_int, 0);
        chk("R5 both bits", rst_cause, 5'b01100);
        clear_cause();
    endtask

    // R7 R8 pin low for n edges
    task automatic t_pin(input int n, input bit exp_set);
        ext_lo = 1'b1; nwait(1);
        chk("R8 rst not yet", rst_int, 0);
        nwait(1);
        chk("R8 rst on", rst_int, 1); chk("R8 no pull", pin_pull_lo, 0);
        nwait(n - 2); ext_lo = 1'b0;
        nwait(4);
        chk("R7 pin bit", rst_cause[0], exp_set);
        chk("R8 rst off", rst_int, 0);
        if (exp_set) clear_cause();
    endtask

    // R9 ignore during reset, R10 same-edge clear and set
    task automatic t_read();
        wdog_req = 1'b1; nwait(1); wdog_req = 1'b0;
        nwait(5); stat_rd = 1'b1; nwait(1); stat_rd = 1'b0;
        chk("R9 read ignored in reset", rst_cause, 5'b01000);
        nwait(DRV + HLD);
        chk("R9 idle", rst_int, 0);
        stat_rd = 1'b1; bad_addr_req = 1'b1; nwait(1);
        stat_rd = 1'b0; bad_addr_req = 1'b0;
        chk("R10 new bit survives", rst_cause, 5'b00010);
        nwait(DRV + HLD + 2);
        clear_cause();
    endtask

    // R11 internal reset clears the low-time count
    task automatic t_count_clear();
        ext_lo = 1'b1; nwait(40);
        wdog_req = 1'b1; nwait(1); wdog_req = 1'b0;
        nwait(DRV + HLD + 40);
        ext_lo = 1'b0; nwait(4);
        chk("R11 pin bit clear", rst_cause, 5'b01000);
        chk("R11 rst off", rst_int, 0);
        clear_cause();
    endtask

    initial begin
        t_por(1'b0);
        t_int(0, 5'b01000);
        t_int(1, 5'b00100);
        t_int(2, 5'b00010);
        t_restart();
        t_pin(PMIN, 1'b1);
        t_pin(PMIN - 1, 1'b0);
        t_read();
        t_count_clear();
        t_por(1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule